// File: doc/BRIEF.md
# Programmable Length Digital Delay Line

The block is a synchronous delay line for an 8-bit data word. A word applied at the input comes out of the output unchanged, a programmable number of clock cycles later. The delay is set by a 4-bit length code. Every register in the block moves on the rising edge of one clock. A synchronous reset clears the stored words and the stored settings.

A parameter selects one of two variants. In the single-group variant all eight bits share one delay of code + 1 cycles, which gives 1 to 16 cycles. In the split-nibble variant the delay is code + 3 cycles, which gives 3 to 18 cycles. In that variant a mode input decides what the upper nibble does. It either follows the lower nibble or stays fixed at the longest delay of 18 cycles.

The length code and the mode bit pass through a register before they reach the output multiplexer. The data chain keeps shifting at all times, so a new setting picks a new tap of a chain that is already full. The output makes no flush and gives no valid indication. The block has no state machine: it is built from a settings register, a shift chain and one tap selector for each nibble group.

Top module: `prog_delay_line`

## Requirements
- R1: Data is never altered. Each bit of `data_out` is a copy of the same bit of `data_in` from an earlier cycle, for any data pattern.
- R2: The data chain shifts on every rising edge whatever the length setting. After the code is shortened, the output at once shows the older words that the chain already holds.
- R3: A value on `len_sel` during clock period p sets the delay seen on `data_out` in period p+1, and not before.
- R4: In the single-group variant (`SPLIT`=0) all eight bits are delayed by `len_sel` + 1 cycles. Code 0 gives 1 cycle and code 15 gives 16 cycles.
- R5: In the split-nibble variant (`SPLIT`=1) with `upper_fixed`=0, both nibbles (bits 3:0 and bits 7:4) are delayed by `len_sel` + 3 cycles, which gives 3 to 18 cycles.
- R6: In the split-nibble variant with `upper_fixed`=1, bits 3:0 are delayed by `len_sel` + 3 cycles and bits 7:4 by 18 cycles, for any code.
- R7: `upper_fixed` is registered together with `len_sel`. A change in period p takes effect in period p+1.
- R8: When `rst` is high at a rising edge, the chain and the stored code and mode are cleared. `data_out` is 0 in the following period. Until fresh words fill the chain, the words that come out are 0. The stored code reads as 0 and the stored mode as shared.
- R9: After a code change the output moves to the new tap in the next period, without a gap and without a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| data_in | input | 8 | Data word entering the chain |
| len_sel | input | 4 | Length code; registered before use |
| upper_fixed | input | 1 | Split variant only: 1 holds bits 7:4 at the longest delay; registered with the code |
| data_out | output | 8 | Delayed data word |

## Verification
In each clock period the output equals the input of the period exactly N periods earlier. N is worked out from the code and mode that were stored at the edge that opened the period, which means the inputs of the period before. When a reset falls inside the window of N periods, the expected output is 0. The bench drives its inputs and samples the outputs at the falling edge. For every period it keeps the effective input word, code and mode and the period of the latest reset. It then computes the expected word of each nibble for both variants and compares it in every period. This covers code changes made in every cycle, mode toggles and a reset in the middle of a run.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

    typedef enum logic {
        GRP_SHARED    = 1'b0,
        GRP_UPPER_MAX = 1'b1
    } grp_mode_e;

    function automatic int min_delay(bit split);
        return split ? 3 : 1;
    endfunction

    function automatic int max_delay(bit split, int code_w);
        return (1 << code_w) + min_delay(split) - 1;
    endfunction

endpackage

// File: rtl/pdl_cfg_reg.sv
module pdl_cfg_reg
    import pdl_pkg::*;
#(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code_in,
    input  logic              mode_in,
    output logic [CODE_W-1:0] code_q,
    output grp_mode_e         mode_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= '0;
            mode_q <= GRP_SHARED;
        end else begin
            code_q <= code_in;
            mode_q <= grp_mode_e'(mode_in);
        end
    end

endmodule

// File: rtl/pdl_shift_chain.sv
module pdl_shift_chain #(
    parameter int W     = 8,
    parameter int DEPTH = 18
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [W-1:0]              d,
    output logic [DEPTH-1:0][W-1:0]   taps
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) taps[0] <= '0;
                else     taps[0] <= d;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) taps[s] <= '0;
                else     taps[s] <= taps[s-1];
            end
        end
    end

    // R2
    r2_head_capture_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> taps[0] == $past(d));

endmodule

// File: rtl/pdl_tap_sel.sv
module pdl_tap_sel #(
    parameter int W      = 4,
    parameter int DEPTH  = 18,
    parameter int CODE_W = 4,
    parameter int OFFSET = 3
) (
    input  logic [DEPTH-1:0][W-1:0] taps,
    input  logic [CODE_W-1:0]       code,
    input  logic                    pin_last,
    output logic [W-1:0]            q
);

    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [IDX_W-1:0] sel;

    always_comb begin
        if (pin_last) sel = IDX_W'(DEPTH - 1);
        else          sel = IDX_W'(code) + IDX_W'(OFFSET - 1);
    end

    always_comb q = taps[sel];

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line
    import pdl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CODE_W = 4,
    parameter bit SPLIT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CODE_W-1:0] len_sel,
    input  logic              upper_fixed,
    output logic [DATA_W-1:0] data_out
);

    localparam int MIN_D = min_delay(SPLIT);
    localparam int MAX_D = max_delay(SPLIT, CODE_W);
    localparam int NGRP  = SPLIT ? 2 : 1;
    localparam int GRP_W = DATA_W / NGRP;
    localparam int AGE_W = $clog2(MIN_D + 1);

    logic [CODE_W-1:0]              code_q;
    grp_mode_e                      mode_q;
    logic [MAX_D-1:0][DATA_W-1:0]   chain_taps;
    logic [AGE_W-1:0]               age;

    pdl_cfg_reg #(.CODE_W(CODE_W)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .code_in (len_sel),
        .mode_in (upper_fixed),
        .code_q  (code_q),
        .mode_q  (mode_q)
    );

    pdl_shift_chain #(.W(DATA_W), .DEPTH(MAX_D)) u_chain (
        .clk  (clk),
        .rst  (rst),
        .d    (data_in),
        .taps (chain_taps)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam bit IS_UPPER = SPLIT && (g == NGRP - 1);

        logic [MAX_D-1:0][GRP_W-1:0] grp_taps;
        logic [GRP_W-1:0]            grp_q;
        logic                        pin;

        always_comb begin
            for (int s = 0; s < MAX_D; s++) begin
                grp_taps[s] = chain_taps[s][g*GRP_W +: GRP_W];
            end
        end

        assign pin = IS_UPPER && (mode_q == GRP_UPPER_MAX);

        pdl_tap_sel #(
            .W(GRP_W), .DEPTH(MAX_D), .CODE_W(CODE_W), .OFFSET(MIN_D)
        ) u_sel (
            .taps     (grp_taps),
            .code     (code_q),
            .pin_last (pin),
            .q        (grp_q)
        );

        assign data_out[g*GRP_W +: GRP_W] = grp_q;
    end

    // edges since reset, saturating; guards the windowed checks below
    always_ff @(posedge clk) begin
        if (rst)                   age <= '0;
        else if (age < AGE_W'(MIN_D)) age <= age + 1'b1;
    end

    // R8
    r8_reset_clears_out_chk: assert property (@(posedge clk)
        rst |=> data_out == '0);

    // R4, R5
    r4_r5_shortest_delay_chk: assert property (@(posedge clk) disable iff (rst)
        (age >= AGE_W'(MIN_D) && code_q == '0)
        |-> data_out[GRP_W-1:0] == $past(data_in[GRP_W-1:0], MIN_D));

    if (SPLIT) begin : g_split_chk
        // R6
        r6_upper_pinned_chk: assert property (@(posedge clk) disable iff (rst)
            (age >= AGE_W'(1) && mode_q == GRP_UPPER_MAX)
            |-> data_out[DATA_W-1 -: GRP_W]
                == $past(chain_taps[MAX_D-2][DATA_W-1 -: GRP_W]));
    end

endmodule

// File: tb/sim_prog_delay_line.sv
module sim_prog_delay_line;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] din;
    logic [3:0] code;
    logic       mode;
    logic [7:0] out_split;
    logic [7:0] out_single;

    int checks = 0;
    int errors = 0;
    int edges  = 0;
    bit done   = 1'b0;

    logic [7:0] hist     [0:4095];
    int         code_eff [0:4095];
    bit         mode_eff [0:4095];
    int         last_rst;

    always #5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    prog_delay_line #(.DATA_W(8), .CODE_W(4), .SPLIT(1'b1)) u0 (
        .clk(clk), .rst(rst), .data_in(din), .len_sel(code),
        .upper_fixed(mode), .data_out(out_split));

    prog_delay_line #(.DATA_W(8), .CODE_W(4), .SPLIT(1'b0)) u1 (
        .clk(clk), .rst(rst), .data_in(din), .len_sel(code),
        .upper_fixed(mode), .data_out(out_single));

    function automatic logic [3:0] nib(int pp, int n, bit hi);
        int src = pp - n;
        if (src <= last_rst) return 4'h0;
        return hi ? hist[src][7:4] : hist[src][3:0];
    endfunction

    function automatic logic [7:0] model(bit split, int pp);
        int c   = code_eff[pp-1];
        bit m   = mode_eff[pp-1];
        int nlo = split ? c + 3 : c + 1;
        int nhi = (split && m) ? 18 : nlo;
        return {nib(pp, nhi, 1'b1), nib(pp, nlo, 1'b0)};
    endfunction

    task automatic check(string tag, string who, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s period %0d: actual=%02h expected=%02h",
                     tag, who, edges, act, exp);
        end
    endtask

    task automatic step(logic [7:0] d, logic [3:0] c, logic m, logic r,
                        string tag_split, string tag_single);
        int p;
        @(negedge clk);
        p = edges;
        if (p >= 1) begin
            check(tag_split,  "split",  out_split,  model(1'b1, p));
            check(tag_single, "single", out_single, model(1'b0, p));
        end
        hist[p]     = r ? 8'h00 : d;
        code_eff[p] = r ? 0 : int'(c);
        mode_eff[p] = r ? 1'b0 : m;
        if (r) last_rst = p;
        din  = d;
        code = c;
        mode = m;
        rst  = r;
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        logic [3:0] cur_c;
        logic       cur_m;
        rst = 1'b1; din = 8'h00; code = 4'h0; mode = 1'b0;
        hist[0] = 8'h00; code_eff[0] = 0; mode_eff[0] = 1'b0; last_rst = 0;
        void'($urandom(32'h5EED_0042));

        // R8: reset state, then stored code reads as 0
        for (int i = 0; i < 3; i++) step(8'hA7, 4'hF, 1'b1, 1'b1, "R8", "R8");
        for (int i = 0; i < 20; i++) step(8'($urandom), 4'h0, 1'b0, 1'b0, "R8", "R8");

        // R5 (split, shared) and R4 (single): every code, random data
        for (int c = 0; c < 16; c++)
            for (int i = 0; i < 30; i++)
                step(8'($urandom), 4'(c), 1'b0, 1'b0, "R5", "R4");

        // R6: upper nibble pinned at 18, lower programmable
        for (int c = 15; c >= 0; c--)
            for (int i = 0; i < 30; i++)
                step(8'($urandom), 4'(c), 1'b1, 1'b0, "R6", "R4");

        // R1: fixed data patterns
        for (int i = 0; i < 40; i++)
            step((i % 2) ? 8'hA5 : 8'h5A, 4'h5, 1'b0, 1'b0, "R1", "R1");
        for (int i = 0; i < 25; i++) step(8'hFF, 4'h2, 1'b0, 1'b0, "R1", "R1");
        for (int i = 0; i < 25; i++) step(8'h00, 4'h2, 1'b0, 1'b0, "R1", "R1");

        // R2: fill at the longest code, then shorten; old words appear at once
        for (int i = 0; i < 30; i++) step(8'(i * 7 + 1), 4'hF, 1'b0, 1'b0, "R2", "R2");
        step(8'h11, 4'h0, 1'b0, 1'b0, "R2", "R2");
        for (int i = 0; i < 4; i++) step(8'h22, 4'h0, 1'b0, 1'b0, "R2", "R2");
        step(8'h33, 4'hF, 1'b0, 1'b0, "R2", "R2");
        for (int i = 0; i < 4; i++) step(8'h44, 4'hF, 1'b0, 1'b0, "R2", "R2");

        // R3: code changes on every cycle
        for (int i = 0; i < 100; i++)
            step(8'($urandom), 4'($urandom), 1'b0, 1'b0, "R3", "R3");

        // R9 and R7: sporadic code changes and mode toggles mid-stream
        cur_c = 4'h4; cur_m = 1'b0;
        for (int i = 0; i < 300; i++) begin
            if ($urandom % 3 == 0) cur_c = 4'($urandom);
            if ($urandom % 4 == 0) cur_m = ~cur_m;
            step(8'($urandom), cur_c, cur_m, 1'b0, (i % 2) ? "R9" : "R7", "R9");
        end

        // R8: reset in the middle of a run
        for (int i = 0; i < 2; i++) step(8'($urandom), 4'hC, 1'b1, 1'b1, "R8", "R8");
        for (int i = 0; i < 25; i++) step(8'($urandom), 4'h9, 1'b1, 1'b0, "R8", "R8");
        step(8'h00, 4'h9, 1'b1, 1'b0, "R8", "R8");

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

endmodule